// File: doc/BRIEF.md
# Packet Timestamp Latch Bank

This block holds hardware timestamps for timing-event packets. When the packet classifier upstream reports a qualified receive event, the block copies the current 64-bit nanosecond time into a free receive slot. There are four such slots. One cycle later it reports which slot was used, so the receive path can send that index along with the packet. Software later fetches the matching slot. A separate single transmit latch captures the time of an outgoing event packet and can raise an interrupt.

Each latch stays occupied until software reads its high word, and that read frees it. A slot that is never read stays occupied forever and blocks any capture that would need it. Events that find no free latch are lost and counted in saturating drop counters. A bulk-clear input frees every latch at once when the timestamping mode changes.

Software reads through a simple port. `rd_data` follows `rd_addr` combinationally. A read takes its side effect at the clock edge where `rd_en` is high.

Top module: `ts_latch_bank`

## Requirements
- R1: After reset, all five latches are free, `rx_done` and `tx_irq` are low, and both drop counters are zero.
- R2: A receive event is captured into the lowest-numbered slot that is free at that clock edge. The slot stores `time_now` as sampled at that edge. In the following cycle `rx_done` is high for one cycle, and `rx_idx` gives the slot number.
- R3: Address 0 reads the status word. Bits 3:0 are the occupied flags of receive slots 0 to 3, bit 4 is the transmit latch occupied flag, and the other bits are zero. Reading it changes no state.
- R4: Receive slot k is read at address 4+2k (low 32 bits) and 5+2k (high 32 bits). Reading the high word frees the slot. Reading the low word leaves the slot occupied.
- R5: A receive event that finds all four slots occupied is not captured and `rx_done` stays low. `rx_drop_cnt` increments, saturating at its maximum (255 by default).
- R6: The transmit latch is read at address 1 (low word) and address 2 (high word). A read of the high word frees the latch.
- R7: A transmit event that arrives while the transmit latch is occupied leaves the stored value unchanged. `tx_drop_cnt` increments, saturating at 255.
- R8: `tx_irq` is high exactly when the transmit latch is occupied and `tx_int_en` is high.
- R9: A cycle with `clr_all` high frees all four receive slots and the transmit latch at that edge.
- R10: A freeing read, or `clr_all`, on the same edge as an event is applied first. The event may then capture into the latch just freed.
- R11: Unused addresses (3 and 12 to 15) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current nanosecond time |
| rx_evt | input | 1 | Qualified receive timing event |
| rx_done | output | 1 | Receive capture made at the previous edge |
| rx_idx | output | 2 | Slot used by that capture |
| tx_evt | input | 1 | Qualified transmit timing event |
| tx_int_en | input | 1 | Transmit interrupt enable |
| tx_irq | output | 1 | Transmit timestamp ready interrupt |
| clr_all | input | 1 | Bulk release of all latches |
| rd_en | input | 1 | Read strobe; applies the read side effect at the edge |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data for `rd_addr` |
| rx_drop_cnt | output | 8 | Saturating count of lost receive events |
| tx_drop_cnt | output | 8 | Saturating count of lost transmit events |

## Verification
`rd_data` is combinational, so the bench compares it in the same cycle, before the edge that would apply the read's release. `rx_done` and `rx_idx` are due one edge after the event, and so are the drop counters, the freed status bits and a change of `tx_irq` caused by a capture. The bench drives each cycle at the falling edge. It checks reads just after that, and checks registered results just after the next rising edge, against a model that applies releases before captures. Random traffic mixes reads, events and clears; directed cases cover a full bank, same-edge release and capture, and counter saturation.

// File: rtl/ts_latch_pkg.sv
package ts_latch_pkg;
  localparam int NRX   = 4;
  localparam int IDX_W = $clog2(NRX);
  localparam int AW    = 4;
  localparam logic [AW-1:0] ADDR_STAT = 4'd0;
  localparam logic [AW-1:0] ADDR_TXL  = 4'd1;
  localparam logic [AW-1:0] ADDR_TXH  = 4'd2;
  localparam int            RX_BASE   = 4;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } pick_t;

  // Lowest set bit of the availability vector.
  function automatic pick_t pick_free(input logic [NRX-1:0] avail);
    pick_t p;
    p.hit = 1'b0;
    p.idx = '0;
    for (int i = NRX - 1; i >= 0; i--) begin
      if (avail[i]) begin
        p.hit = 1'b1;
        p.idx = IDX_W'(i);
      end
    end
    return p;
  endfunction

  function automatic logic [AW-1:0] rx_lo_addr(input int k);
    return AW'(RX_BASE + 2 * k);
  endfunction

  function automatic logic [AW-1:0] rx_hi_addr(input int k);
    return AW'(RX_BASE + 2 * k + 1);
  endfunction
endpackage

// File: rtl/ts_capture_slot.sv
module ts_capture_slot #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          rel,
  input  logic [TW-1:0] t_in,
  output logic          occ,
  output logic [TW-1:0] ts
);
  // Release is applied first; a capture on the same edge wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= 1'b0;
      ts  <= '0;
    end else if (cap) begin
      occ <= 1'b1;
      ts  <= t_in;
    end else if (rel) begin
      occ <= 1'b0;
    end
  end
endmodule

// File: rtl/ts_read_mux.sv
module ts_read_mux
  import ts_latch_pkg::*;
#(
  parameter int TW = 64
) (
  input  logic [AW-1:0]          rd_addr,
  input  logic [NRX-1:0]         occ_rx,
  input  logic                   occ_tx,
  input  logic [NRX-1:0][TW-1:0] rx_ts,
  input  logic [TW-1:0]          tx_ts,
  output logic [TW/2-1:0]        rd_data
);
  localparam int RW = TW / 2;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_STAT) begin
      rd_data = RW'({occ_tx, occ_rx});
    end else if (rd_addr == ADDR_TXL) begin
      rd_data = tx_ts[RW-1:0];
    end else if (rd_addr == ADDR_TXH) begin
      rd_data = tx_ts[TW-1:RW];
    end else begin
      for (int k = 0; k < NRX; k++) begin
        if (rd_addr == rx_lo_addr(k)) rd_data = rx_ts[k][RW-1:0];
        if (rd_addr == rx_hi_addr(k)) rd_data = rx_ts[k][TW-1:RW];
      end
    end
  end
endmodule

// File: rtl/ts_latch_bank.sv
module ts_latch_bank
  import ts_latch_pkg::*;
#(
  parameter int TW    = 64,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    time_now,
  input  logic             rx_evt,
  output logic             rx_done,
  output logic [IDX_W-1:0] rx_idx,
  input  logic             tx_evt,
  input  logic             tx_int_en,
  output logic             tx_irq,
  input  logic             clr_all,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [TW/2-1:0]  rd_data,
  output logic [CNT_W-1:0] rx_drop_cnt,
  output logic [CNT_W-1:0] tx_drop_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  // Named internal events, also used by the checker.
  logic [NRX-1:0]         occ_rx, rel_rx, cap_rx, avail_rx;
  logic [NRX-1:0][TW-1:0] rx_ts;
  logic                   occ_tx, rel_tx, cap_tx;
  logic [TW-1:0]          tx_ts;
  logic                   rx_drop_ev, tx_drop_ev;
  pick_t                  pick;

  assign rel_tx     = clr_all | (rd_en && rd_addr == ADDR_TXH);
  assign cap_tx     = tx_evt && (!occ_tx || rel_tx);
  assign tx_drop_ev = tx_evt && !cap_tx;

  assign avail_rx   = ~(occ_rx & ~rel_rx);
  assign pick       = pick_free(avail_rx);
  assign rx_drop_ev = rx_evt && !pick.hit;

  for (genvar k = 0; k < NRX; k++) begin : g_rx
    assign rel_rx[k] = clr_all | (rd_en && rd_addr == rx_hi_addr(k));
    assign cap_rx[k] = rx_evt && pick.hit && (pick.idx == IDX_W'(k));

    ts_capture_slot #(.TW(TW)) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .cap  (cap_rx[k]),
      .rel  (rel_rx[k]),
      .t_in (time_now),
      .occ  (occ_rx[k]),
      .ts   (rx_ts[k])
    );
  end

  ts_capture_slot #(.TW(TW)) u_tx_slot (
    .clk  (clk),
    .rst_n(rst_n),
    .cap  (cap_tx),
    .rel  (rel_tx),
    .t_in (time_now),
    .occ  (occ_tx),
    .ts   (tx_ts)
  );

  ts_read_mux #(.TW(TW)) u_mux (
    .rd_addr(rd_addr),
    .occ_rx (occ_rx),
    .occ_tx (occ_tx),
    .rx_ts  (rx_ts),
    .tx_ts  (tx_ts),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_done     <= 1'b0;
      rx_idx      <= '0;
      rx_drop_cnt <= '0;
      tx_drop_cnt <= '0;
    end else begin
      rx_done <= rx_evt && pick.hit;
      if (rx_evt && pick.hit) rx_idx <= pick.idx;
      if (rx_drop_ev) rx_drop_cnt <= sat_inc(rx_drop_cnt);
      if (tx_drop_ev) tx_drop_cnt <= sat_inc(tx_drop_cnt);
    end
  end

  assign tx_irq = occ_tx & tx_int_en;
endmodule

// File: rtl/ts_latch_bank_chk.sv
module ts_latch_bank_chk
  import ts_latch_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_evt,
  input logic             tx_evt,
  input logic             tx_int_en,
  input logic             clr_all,
  input logic             rx_done,
  input logic [IDX_W-1:0] rx_idx,
  input logic             tx_irq,
  input logic [NRX-1:0]   occ_rx,
  input logic [NRX-1:0]   rel_rx,
  input logic [NRX-1:0]   cap_rx,
  input logic             occ_tx,
  input logic [CNT_W-1:0] rx_drop_cnt,
  input logic [CNT_W-1:0] tx_drop_cnt
);
  assert_done_slot_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> occ_rx[rx_idx]);

  assert_one_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_rx));

  assert_full_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && (&occ_rx) && !(|rel_rx)) |=> !rx_done);

  assert_rx_cnt_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop_cnt >= $past(rx_drop_cnt));

  assert_tx_cnt_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop_cnt >= $past(tx_drop_cnt));

  assert_irq_on_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt && !occ_tx && tx_int_en && $stable(tx_int_en)) |=> (tx_irq || !tx_int_en));

  assert_bulk_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !rx_evt && !tx_evt) |=> (occ_rx == '0 && !occ_tx));

  for (genvar k = 0; k < NRX; k++) begin : g_slot
    assert_release_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_rx[k] && !cap_rx[k]) |=> !occ_rx[k]);
    assert_release_then_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_rx[k] && cap_rx[k]) |=> occ_rx[k]);
  end
endmodule

bind ts_latch_bank ts_latch_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_evt     (rx_evt),
  .tx_evt     (tx_evt),
  .tx_int_en  (tx_int_en),
  .clr_all    (clr_all),
  .rx_done    (rx_done),
  .rx_idx     (rx_idx),
  .tx_irq     (tx_irq),
  .occ_rx     (occ_rx),
  .rel_rx     (rel_rx),
  .cap_rx     (cap_rx),
  .occ_tx     (occ_tx),
  .rx_drop_cnt(rx_drop_cnt),
  .tx_drop_cnt(tx_drop_cnt)
);

// File: tb/ts_latch_bank_bench.sv
module ts_latch_bank_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        rx_evt = 1'b0, tx_evt = 1'b0, tx_int_en = 1'b0, clr_all = 1'b0, rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic        rx_done, tx_irq;
  logic [1:0]  rx_idx;
  logic [31:0] rd_data;
  logic [7:0]  rx_drop_cnt, tx_drop_cnt;

  int checks = 0, failures = 0;
  bit finished = 0;

  // Bench model
  bit          m_occ [4];
  logic [63:0] m_ts  [4];
  bit          m_tocc;
  logic [63:0] m_tts;
  int          m_rxd, m_txd;

  ts_latch_bank u_ts_latch_bank (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .rx_evt(rx_evt), .rx_done(rx_done), .rx_idx(rx_idx),
    .tx_evt(tx_evt), .tx_int_en(tx_int_en), .tx_irq(tx_irq),
    .clr_all(clr_all), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rx_drop_cnt(rx_drop_cnt), .tx_drop_cnt(tx_drop_cnt)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected read word per address map
  function automatic logic [31:0] mread(input logic [3:0] a);
    logic [31:0] r;
    r = 32'h0;
    if (a == 4'd0) r = {27'h0, m_tocc, m_occ[3], m_occ[2], m_occ[1], m_occ[0]};
    else if (a == 4'd1) r = m_tts[31:0];
    else if (a == 4'd2) r = m_tts[63:32];
    else if (a >= 4'd4 && a <= 4'd11) r = a[0] ? m_ts[(a-4)/2][63:32] : m_ts[(a-4)/2][31:0];
    return r;
  endfunction

  function automatic string addr_req(input logic [3:0] a);
    if (a == 0) return "R3";
    if (a == 1 || a == 2) return "R6";
    if (a == 3 || a >= 12) return "R11";
    return "R4";
  endfunction

  task automatic step(input bit rx, input bit tx, input bit rd, input logic [3:0] a,
                      input bit clr, input bit en, input string tag);
    bit          exp_done;
    int          exp_idx;
    string       rq;
    @(negedge clk);
    rx_evt = rx; tx_evt = tx; rd_en = rd; rd_addr = a; clr_all = clr; tx_int_en = en;
    time_now = time_now + 64'h0000_0001_0000_0013;
    #1;
    rq = (tag != "") ? tag : addr_req(a);
    if (rd) chk(rq, rd_data, mread(a));
    chk("R8", tx_irq, m_tocc & en);
    // Releases first
    if (clr) begin
      for (int k = 0; k < 4; k++) m_occ[k] = 0;
      m_tocc = 0;
    end
    if (rd && a == 4'd2) m_tocc = 0;
    if (rd && a >= 4'd4 && a <= 4'd11 && a[0]) m_occ[(a-4)/2] = 0;
    // Then captures
    exp_done = 0; exp_idx = 0;
    if (rx) begin
      for (int k = 3; k >= 0; k--) if (!m_occ[k]) begin exp_done = 1; exp_idx = k; end
      if (exp_done) begin m_occ[exp_idx] = 1; m_ts[exp_idx] = time_now; end
      else if (m_rxd < 255) m_rxd++;
    end
    if (tx) begin
      if (!m_tocc) begin m_tocc = 1; m_tts = time_now; end
      else if (m_txd < 255) m_txd++;
    end
    @(posedge clk);
    #1;
    chk((tag != "") ? tag : "R2", rx_done, exp_done);
    if (exp_done) chk((tag != "") ? tag : "R2", rx_idx, exp_idx);
    chk("R5", rx_drop_cnt, m_rxd);
    chk("R7", tx_drop_cnt, m_txd);
    chk("R8", tx_irq, m_tocc & en);
  endtask

  task automatic idle();
    step(0, 0, 0, 4'd0, 0, tx_int_en, "");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int k = 0; k < 4; k++) begin m_occ[k] = 0; m_ts[k] = '0; end
    m_tocc = 0; m_tts = '0; m_rxd = 0; m_txd = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", rx_done, 0);
    chk("R1", tx_irq, 0);
    chk("R1", rx_drop_cnt, 0);
    chk("R1", tx_drop_cnt, 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 1, 4'd0, 0, 0, "R1");

    // R2 fill in order, R5 drop when full
    for (int k = 0; k < 4; k++) step(1, 0, 0, 4'd0, 0, 0, "R2");
    step(1, 0, 0, 4'd0, 0, 0, "R5");
    step(0, 0, 1, 4'd0, 0, 0, "R3");
    step(0, 0, 1, 4'd0, 0, 0, "R3");   // status read has no side effect
    // R4 low read keeps slot, high read frees it
    step(0, 0, 1, 4'd8, 0, 0, "R4");
    step(0, 0, 1, 4'd0, 0, 0, "R4");
    step(0, 0, 1, 4'd9, 0, 0, "R4");
    step(0, 0, 1, 4'd0, 0, 0, "R4");
    step(1, 0, 0, 4'd0, 0, 0, "R2");   // lowest free is slot 2
    // R10 full bank, release slot 1 and capture on same edge
    step(1, 0, 1, 4'd7, 0, 0, "R10");
    step(0, 0, 1, 4'd6, 0, 0, "R10");
    step(0, 0, 1, 4'd7, 0, 0, "R10");
    // R6 R7 R8 transmit
    step(0, 1, 0, 4'd0, 0, 1, "R8");
    step(0, 1, 0, 4'd0, 0, 1, "R7");
    step(0, 0, 1, 4'd1, 0, 1, "R6");
    step(0, 0, 1, 4'd0, 0, 1, "R6");
    step(0, 0, 1, 4'd2, 0, 1, "R6");
    step(0, 0, 1, 4'd0, 0, 0, "R8");
    step(0, 1, 1, 4'd2, 0, 0, "R10");  // tx free and capture same edge
    step(0, 1, 1, 4'd2, 0, 1, "R10");
    // R11 unused addresses
    step(0, 0, 1, 4'd3, 0, 1, "R11");
    step(0, 0, 1, 4'd14, 0, 1, "R11");
    // R9 bulk clear
    step(1, 1, 0, 4'd0, 0, 1, "");
    step(0, 0, 0, 4'd0, 1, 1, "R9");
    step(0, 0, 1, 4'd0, 0, 1, "R9");
    step(1, 0, 0, 4'd0, 1, 1, "R10"); // clear then capture into slot 0

    // Constrained random traffic
    for (int i = 0; i < 800; i++) begin
      step(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0,
           4'($urandom % 16), ($urandom % 40) == 0,
           (($urandom % 8) != 0), "");
    end

    // Saturation of both drop counters
    step(0, 0, 0, 4'd0, 1, 1, "R9");
    for (int k = 0; k < 4; k++) step(1, 1, 0, 4'd0, 0, 1, "R2");
    for (int i = 0; i < 300; i++) step(1, 1, 0, 4'd0, 0, 1, "");
    chk("R5", rx_drop_cnt, 8'd255);
    chk("R7", tx_drop_cnt, 8'd255);
    idle();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule